// File: doc/BRIEF.md
# Ping-pong frame buffer controller

This block sits between a pixel producer, a display scan-out reader and an external memory that holds two whole frames. The producer fills one frame area while the display scans the other. When the producer finishes a frame, that frame becomes the one the display will show, and the producer moves on to the other area. The block does not handle pixel data. It only generates the memory addresses for both sides and tells the system which area is on screen.

The top address bit selects the frame area, and the lower bits give the pixel offset inside the frame. The write side alone decides which area is the newest complete one. The read side only counts offsets. At each display frame start it takes the newest complete area, so it needs no handshake with the producer. Because the displayed area is only picked up at a display frame start, a frame that completes during a scan appears from the next scan, and the picture does not tear.

The defaults give 1024 by 768 pixels. That is 786,432 pixel offsets, a 20-bit offset and a 21-bit address. At 24 bits per pixel each area takes 2,359,296 bytes, and a 60 Hz display reads about 141.6 MB/s.

Top module: `pingpong_fb_ctrl`

## Requirements
- R1: After reset, the writer targets area 0 at offset 0, so `wr_addr` = 0. The display shows area 1 at offset 0, so `rd_addr` = {1, 0} and `disp_buf` = 1.
- R2: Each `wr_pix` pulse without `wr_sof` moves the write offset (the low bits of `wr_addr`) up by one. The top bit of `wr_addr` is the writer's current area.
- R3: A `wr_pix` pulse at the last offset (frame size minus 1) returns the write offset to 0. It flips the writer's area and records the area just finished as the newest complete one.
- R4: `wr_sof` sets the write offset to 0 without changing the writer's area and without completing a frame. It takes priority over `wr_pix` in the same cycle.
- R5: Each `rd_pix` pulse without `rd_sof` moves the read offset (the low bits of `rd_addr`) up by one. After the last offset it wraps to 0. A read wrap never changes the displayed area.
- R6: `rd_sof` sets the read offset to 0 and loads the newest complete area into `disp_buf`, which is also the top bit of `rd_addr`. This includes a frame that completes in that same cycle. `rd_sof` takes priority over `rd_pix`.
- R7: `disp_buf` changes only in the cycle after `rd_sof`. A frame that completes during a scan leaves the current scan's area unchanged.
- R8: If several frames complete between two `rd_sof` pulses, the next `rd_sof` loads the most recent of them.
- R9: The writer's current area always differs from the newest complete area. So right after an `rd_sof` with no completion in that cycle, `disp_buf` differs from the top bit of `wr_addr`.
- R10: In cycles without strobes, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_sof | input | 1 | Producer start-of-frame pulse |
| wr_pix | input | 1 | Producer pixel strobe, one per written pixel |
| rd_sof | input | 1 | Display frame start (vertical sync) pulse |
| rd_pix | input | 1 | Display pixel request, one per fetched pixel |
| wr_addr | output | ADDR_W | Write address: area bit on top, pixel offset below |
| rd_addr | output | ADDR_W | Read address: displayed area bit on top, pixel offset below |
| disp_buf | output | 1 | Area currently being displayed |

## Verification
The hardest case to reach from the ports is a frame completion in the same cycle as a display frame start. A close second is several completions stacked between two display frame starts. The bench reaches the first by stepping the write offset to its last value and then raising `wr_pix` and `rd_sof` in the same cycle. It reaches the second by writing three whole small frames with no `rd_sof` in between. It uses a 4 by 3 frame so that wraps come every twelve pixels. A long run of pseudo-random strobes then mixes these cases with start-of-frame collisions. A behavioural model is compared against the outputs on every clock.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic {
    AREA_0 = 1'b0,
    AREA_1 = 1'b1
  } area_e;

  function automatic area_e other_area(area_e a);
    return (a == AREA_0) ? AREA_1 : AREA_0;
  endfunction
endpackage

// File: rtl/fb_offset_ctr.sv
module fb_offset_ctr #(
  parameter int DEPTH = 786432,
  localparam int W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] off,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(DEPTH - 1);

  logic [W-1:0] off_d;
  logic         off_en;

  always_comb begin
    wrap   = adv && !clr && (off == LAST);
    off_en = clr || adv;
    if (clr || wrap) off_d = '0;
    else             off_d = off + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off <= '0;
    else if (off_en) off <= off_d;
  end

  // R2
  off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off <= LAST);
  // R2
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && off != LAST) |=> (off == $past(off) + W'(1)));
  // R4
  off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (off == '0));
  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(off));
endmodule

// File: rtl/fb_write_area.sv
module fb_write_area
  import fb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_done,
  output area_e wr_area,
  output area_e done_area
);
  area_e wr_area_d;
  area_e done_area_d;

  always_comb begin
    wr_area_d   = other_area(wr_area);
    done_area_d = wr_area;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_area   <= AREA_0;
      done_area <= AREA_1;
    end else if (frame_done) begin
      wr_area   <= wr_area_d;
      done_area <= done_area_d;
    end
  end

  // R9
  area_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_area != done_area);
  // R3
  area_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (done_area == $past(wr_area)) && (wr_area != $past(wr_area)));
  // R10
  area_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(wr_area) && $stable(done_area));
endmodule

// File: rtl/fb_scan_select.sv
module fb_scan_select
  import fb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_sof,
  input  logic  frame_done,
  input  area_e wr_area,
  input  area_e done_area,
  output area_e disp_area
);
  area_e newest;

  always_comb begin
    newest = frame_done ? wr_area : done_area;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      disp_area <= AREA_1;
    else if (rd_sof) disp_area <= newest;
  end

  // R7
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sof |=> $stable(disp_area));
  // R6
  disp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sof && !frame_done) |=> (disp_area == $past(done_area)));
  // R6
  disp_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sof && frame_done) |=> (disp_area == $past(wr_area)));
endmodule

// File: rtl/pingpong_fb_ctrl.sv
module pingpong_fb_ctrl
  import fb_pkg::*;
#(
  parameter int  H_PIXELS  = 1024,
  parameter int  V_LINES   = 768,
  localparam int FRAME_PIX = H_PIXELS * V_LINES,
  localparam int OFF_W     = $clog2(FRAME_PIX),
  localparam int ADDR_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sof,
  input  logic              wr_pix,
  input  logic              rd_sof,
  input  logic              rd_pix,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              disp_buf
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic [OFF_W-1:0] wr_off;
  logic [OFF_W-1:0] rd_off;
  logic             wr_wrap;
  logic             rd_wrap;
  area_e            wr_area;
  area_e            done_area;
  area_e            disp_area;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  fb_offset_ctr #(.DEPTH(FRAME_PIX)) u_wr_ctr (
    .clk(clk), .rst_n(rst_core_n), .clr(wr_sof), .adv(wr_pix),
    .off(wr_off), .wrap(wr_wrap)
  );

  fb_offset_ctr #(.DEPTH(FRAME_PIX)) u_rd_ctr (
    .clk(clk), .rst_n(rst_core_n), .clr(rd_sof), .adv(rd_pix),
    .off(rd_off), .wrap(rd_wrap)
  );

  fb_write_area u_wr_area (
    .clk(clk), .rst_n(rst_core_n), .frame_done(wr_wrap),
    .wr_area(wr_area), .done_area(done_area)
  );

  fb_scan_select u_scan_sel (
    .clk(clk), .rst_n(rst_core_n), .rd_sof(rd_sof), .frame_done(wr_wrap),
    .wr_area(wr_area), .done_area(done_area), .disp_area(disp_area)
  );

  assign wr_addr  = {logic'(wr_area), wr_off};
  assign rd_addr  = {logic'(disp_area), rd_off};
  assign disp_buf = logic'(disp_area);

  // R5
  rd_wrap_area_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_wrap && !rd_sof) |=> (rd_addr[ADDR_W-1] == $past(rd_addr[ADDR_W-1])) && (rd_off == '0));
  // R3
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_wrap |=> (wr_off == '0) && (wr_addr[ADDR_W-1] != $past(wr_addr[ADDR_W-1])));
endmodule

// File: tb/pingpong_fb_ctrl_bench.sv
module pingpong_fb_ctrl_bench;
  localparam int H = 4;
  localparam int V = 3;
  localparam int FR = H * V;
  localparam int OW = $clog2(FR);
  localparam int AW = OW + 1;
  localparam int AREA_STEP = 1 << OW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wr_sof, wr_pix, rd_sof, rd_pix;
  logic [AW-1:0] wr_addr, rd_addr;
  logic disp_buf;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int m_woff, m_wbank, m_done, m_roff, m_disp;

  pingpong_fb_ctrl #(.H_PIXELS(H), .V_LINES(V)) u_pingpong_fb_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_sof(wr_sof), .wr_pix(wr_pix),
    .rd_sof(rd_sof), .rd_pix(rd_pix), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .disp_buf(disp_buf)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit ws, bit wp, bit rs, bit rp);
    wr_sof = ws; wr_pix = wp; rd_sof = rs; rd_pix = rp;
    @(posedge clk);
    if (ws) m_woff = 0;
    else if (wp) begin
      if (m_woff == FR - 1) begin
        m_woff = 0;
        m_done = m_wbank;
        m_wbank = 1 - m_wbank;
      end else m_woff++;
    end
    if (rs) begin
      m_roff = 0;
      m_disp = m_done;
    end else if (rp) m_roff = (m_roff == FR - 1) ? 0 : m_roff + 1;
    @(negedge clk);
    chk("R2/R3 model wr_addr", int'(wr_addr), m_wbank * AREA_STEP + m_woff);
    chk("R5/R6 model rd_addr", int'(rd_addr), m_disp * AREA_STEP + m_roff);
    chk("R7 model disp_buf", int'(disp_buf), m_disp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R10 progress): actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int hold_w, hold_r;
    rst_n = 1'b0; wr_sof = 0; wr_pix = 0; rd_sof = 0; rd_pix = 0;
    m_woff = 0; m_wbank = 0; m_done = 1; m_roff = 0; m_disp = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_addr", int'(wr_addr), 0);
    chk("R1 rd_addr", int'(rd_addr), AREA_STEP);
    chk("R1 disp_buf", int'(disp_buf), 1);

    // R2 write pixels with a gap
    step(0, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    chk("R2 offset after four pixels", int'(wr_addr), 4);

    // R5 read advance
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    chk("R5 read offset", int'(rd_addr), AREA_STEP + 3);

    // R7 finish the frame mid-scan
    for (int i = 0; i < FR - 4; i++) step(0, 1, 0, 1);
    chk("R3 writer moved to area 1", int'(wr_addr), AREA_STEP);
    chk("R7 display unchanged mid-scan", int'(disp_buf), 1);

    // R6 frame start picks up area 0
    step(0, 0, 1, 0);
    chk("R6 disp_buf after frame start", int'(disp_buf), 0);
    chk("R6 rd_addr after frame start", int'(rd_addr), 0);
    // R9
    chk("R9 display differs from writer", int'(disp_buf ^ wr_addr[AW-1]), 1);

    // R4 write start-of-frame collides with a pixel
    step(0, 1, 0, 0); step(0, 1, 0, 0); step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    chk("R4 write offset cleared, area kept", int'(wr_addr), AREA_STEP);

    // R8 three completions before the next frame start
    for (int i = 0; i < 3 * FR; i++) step(0, 1, 0, 0);
    chk("R8 writer area after three frames", int'(wr_addr), 0);
    chk("R7 display still stale", int'(disp_buf), 0);
    step(0, 0, 1, 1);
    chk("R8 newest complete area latched", int'(disp_buf), 1);
    chk("R6 rd_sof beats rd_pix", int'(rd_addr), AREA_STEP);

    // R5 read wrap keeps area
    for (int i = 0; i < FR; i++) step(0, 0, 0, 1);
    chk("R5 read wrap", int'(rd_addr), AREA_STEP);

    // R6 completion in the same cycle as frame start
    for (int i = 0; i < FR - 1; i++) step(0, 1, 0, 0);
    step(0, 1, 1, 1);
    chk("R6 same-cycle completion shown", int'(disp_buf), 0);
    chk("R6 same-cycle rd_addr", int'(rd_addr), 0);

    // R10 idle cycles hold everything
    step(0, 1, 0, 1);
    hold_w = int'(wr_addr);
    hold_r = int'(rd_addr);
    repeat (5) step(0, 0, 0, 0);
    chk("R10 wr_addr held", int'(wr_addr), hold_w);
    chk("R10 rd_addr held", int'(rd_addr), hold_r);

    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(39) == 0, $urandom_range(9) < 7,
           $urandom_range(29) == 0, $urandom_range(9) < 8);
    end

    step(0, 0, 0, 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule